// File: doc/BRIEF.md
# Mask-Steered Bit Gather, Scatter and Split Unit

This block rearranges the bits of a 64-bit word under the control of a second 64-bit word used as a selection mask. Where a conventional field operation needs a start position and a width, here any set of bit positions may be chosen at once, contiguous or not. A request carries an operation code, a source word and a mask, and is marked by a one-cycle valid strobe. The answer appears on a registered output one clock later, with its own valid flag.

Three operations are offered, plus a pass-through.

Gather packs the chosen source bits into the low end of the result. Scatter spreads the low source bits out into the chosen positions. Split sends the chosen bits to the high end of the word and the other bits to the low end, and keeps each group in its original order. Requests may arrive on every cycle, and there is no back-pressure.

Top module: `bmx_unit`

## Requirements
- R1: Operation code 2'b00 (gather). The source bits at positions where the mask is one are packed into the result from bit 0 upward, in ascending order of source position. All result bits above the packed group are zero.
- R2: Operation code 2'b01 (scatter). Source bit k goes to the position of the k-th lowest set bit of the mask, counting k from 0. Result bits at positions where the mask is zero are zero.
- R3: Operation code 2'b10 (split). The source bits at mask-one positions occupy the top of the result, and the source bits at mask-zero positions occupy the bottom. Each group keeps its ascending source order, so the result holds as many ones as the source.
- R4: With an all-zero mask, gather and scatter give zero and split returns the source unchanged.
- R5: Operation code 2'b11 returns the source unchanged, whatever the mask holds.
- R6: For every cycle in which valid_i is high, valid_o is high in the following cycle, and result_o then holds the answer to that request. Requests on consecutive cycles are each answered in order.
- R7: In the cycle after valid_i is low, valid_o is low and result_o keeps its previous value.
- R8: While rst_ni is low, valid_o and result_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 2 | Operation code: 00 gather, 01 scatter, 10 split, 11 pass |
| src_i | input | 64 | Source word |
| mask_i | input | 64 | Selection mask |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 64 | Registered result |

## Verification
Two things can fall in the same cycle: a new request being accepted, and the answer to the previous request being presented. The case matters most when the two requests use different operation codes. The bench provokes it with long runs of back-to-back strobes that rotate through all four codes, using mixed random and corner masks, and inserts idle gaps between the runs. A scoreboard queues the expected word for each strobe and pops it in the cycle after that strobe. Any shifted, swapped or stale answer therefore shows up as a mismatch, and so does a hold violation in an idle cycle.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
  typedef enum logic [1:0] {
    OP_GATHER  = 2'b00,
    OP_SCATTER = 2'b01,
    OP_SPLIT   = 2'b10,
    OP_THRU    = 2'b11
  } bmx_op_e;
endpackage

// File: rtl/bmx_gather.sv
// Packs data bits at mask-one positions into the low end, ascending order.
module bmx_gather #(
  parameter int W  = 64,
  parameter int IW = $clog2(W),
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  data_i,
  input  logic [W-1:0]  mask_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] n;

  always_comb begin
    data_o = '0;
    n      = '0;
    for (int i = 0; i < W; i++) begin
      if (mask_i[i]) begin
        data_o[n[IW-1:0]] = data_i[i];
        n = n + CW'(1);
      end
    end
  end

  assign cnt_o = n;
endmodule

// File: rtl/bmx_scatter.sv
// Places low data bits, in order, at mask-one positions; others zero.
module bmx_scatter #(
  parameter int W  = 64,
  parameter int IW = $clog2(W),
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] data_o
);
  logic [CW-1:0] n;

  always_comb begin
    data_o = '0;
    n      = '0;
    for (int i = 0; i < W; i++) begin
      if (mask_i[i]) begin
        data_o[i] = data_i[n[IW-1:0]];
        n = n + CW'(1);
      end
    end
  end
endmodule

// File: rtl/bmx_unit.sv
module bmx_unit
  import bmx_pkg::*;
#(
  parameter int W = 64,
  localparam int CW = $clog2(W) + 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] mask_i,
  output logic         valid_o,
  output logic [W-1:0] result_o
);
  bmx_op_e       op;
  logic [W-1:0]  sel_lo, uns_lo, dep, split_w, nxt;
  logic [CW-1:0] n_sel, n_uns, sh;

  assign op = bmx_op_e'(op_i);

  bmx_gather #(.W(W)) u_gather_sel (
    .data_i(src_i), .mask_i(mask_i),  .data_o(sel_lo), .cnt_o(n_sel)
  );
  bmx_gather #(.W(W)) u_gather_uns (
    .data_i(src_i), .mask_i(~mask_i), .data_o(uns_lo), .cnt_o(n_uns)
  );
  bmx_scatter #(.W(W)) u_scatter (
    .data_i(src_i), .mask_i(mask_i), .data_o(dep)
  );

  // Selected group lifted to the top; a shift of W clears it (empty mask).
  assign sh      = CW'(W) - n_sel;
  assign split_w = (n_sel == '0) ? uns_lo : ((sel_lo << sh) | uns_lo);

  always_comb begin
    unique case (op)
      OP_GATHER:  nxt = sel_lo;
      OP_SCATTER: nxt = dep;
      OP_SPLIT:   nxt = split_w;
      default:    nxt = src_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= nxt;
    end
  end

  p_lat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o)));
  p_gather_top_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b00 && mask_i == '0) |=> result_o == '0);
  p_scatter_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b01) |=> (result_o & ~$past(mask_i)) == '0);
  p_split_ones_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b10) |=> $countones(result_o) == $countones($past(src_i)));
  p_split_cnt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (n_sel + n_uns) == CW'(W));
  p_thru_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b11) |=> result_o == $past(src_i));
  p_split_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b10 && mask_i == '0) |=> result_o == $past(src_i));
endmodule

// File: tb/bmx_unit_tb_top.sv
module bmx_unit_tb_top;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   op_i = 2'b00;
  logic [W-1:0] src_i = '0;
  logic [W-1:0] mask_i = '0;
  logic         valid_o;
  logic [W-1:0] result_o;

  always #5 clk = ~clk;

  bmx_unit #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .src_i(src_i), .mask_i(mask_i), .valid_o(valid_o), .result_o(result_o)
  );

  typedef struct {
    logic [W-1:0] val;
    string        tag;
  } exp_t;

  exp_t sbq[$];
  int   checks = 0;
  int   fails  = 0;
  bit   mon_en = 1'b0;
  bit   ended  = 1'b0;

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Reference: built top-down by shifting, independent of the RTL loop.
  function automatic logic [W-1:0] ref_gather(logic [W-1:0] s, logic [W-1:0] m);
    logic [W-1:0] r = '0;
    for (int i = W - 1; i >= 0; i--)
      if (m[i]) r = {r[W-2:0], s[i]};
    return r;
  endfunction

  function automatic logic [W-1:0] ref_scatter(logic [W-1:0] s, logic [W-1:0] m);
    logic [W-1:0] r = '0;
    logic [W-1:0] mm = m;
    logic [W-1:0] low;
    int k = 0;
    while (mm != '0) begin
      low = mm & (~mm + 1'b1);
      if (s[k]) r = r | low;
      mm = mm & (mm - 1'b1);
      k++;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_split(logic [W-1:0] s, logic [W-1:0] m);
    int n = $countones(m);
    logic [W-1:0] hi = ref_gather(s, m);
    logic [W-1:0] lo = ref_gather(s, ~m);
    if (n == 0) return lo;
    return (hi << (W - n)) | lo;
  endfunction

  function automatic logic [W-1:0] ref_model(logic [1:0] op, logic [W-1:0] s, logic [W-1:0] m);
    case (op)
      2'b00:   return ref_gather(s, m);
      2'b01:   return ref_scatter(s, m);
      2'b10:   return ref_split(s, m);
      default: return s;
    endcase
  endfunction

  function automatic string op_tag(logic [1:0] op);
    case (op)
      2'b00:   return "R1 gather";
      2'b01:   return "R2 scatter";
      2'b10:   return "R3 split";
      default: return "R5 pass";
    endcase
  endfunction

  task automatic send_exp(logic [1:0] op, logic [W-1:0] s, logic [W-1:0] m,
                          logic [W-1:0] exp, string tag);
    exp_t e;
    @(negedge clk);
    valid_i = 1'b1;
    op_i    = op;
    src_i   = s;
    mask_i  = m;
    e.val = exp;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic send(logic [1:0] op, logic [W-1:0] s, logic [W-1:0] m);
    send_exp(op, s, m, ref_model(op, s, m), op_tag(op));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      src_i   = {$urandom, $urandom};
      mask_i  = {$urandom, $urandom};
      op_i    = 2'($urandom);
    end
  endtask

  // Monitor: strobe seen at an edge must be answered by the next negedge.
  initial begin
    logic         ev;
    logic [W-1:0] prev;
    exp_t         e;
    prev = '0;
    wait (mon_en);
    forever begin
      @(posedge clk);
      ev = valid_i;
      @(negedge clk);
      check(ev ? "R6 valid" : "R7 valid", {{(W-1){1'b0}}, valid_o}, {{(W-1){1'b0}}, ev});
      if (ev) begin
        if (sbq.size() == 0) begin
          check("R6 queue", '1, '0);
        end else begin
          e = sbq.pop_front();
          check(e.tag, result_o, e.val);
        end
      end else begin
        check("R7 hold", result_o, prev);
      end
      prev = result_o;
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [W-1:0] s, m;
    #12;
    check("R8 reset result", result_o, '0);
    check("R8 reset valid", {{(W-1){1'b0}}, valid_o}, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    mon_en = 1'b1;
    idle(2);

    // Hand-computed cases
    send_exp(2'b00, 64'hFEDC_BA98_7654_3210, 64'h0000_0000_0000_FF00,
             64'h0000_0000_0000_0032, "R1 byte gather");
    send_exp(2'b00, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001,
             64'h0000_0000_0000_0003, "R1 end bits");
    send_exp(2'b01, 64'h0000_0000_0000_00AB, 64'h0000_0000_0000_F0F0,
             64'h0000_0000_0000_A0B0, "R2 nibble scatter");
    send_exp(2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
             64'h8000_0000_0000_0000, "R2 top bit");
    send_exp(2'b10, 64'h0000_0000_0000_1234, 64'h0000_0000_0000_00FF,
             64'h3400_0000_0000_0012, "R3 split");
    send_exp(2'b10, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF,
             64'h1234_5678_9ABC_DEF0, "R3 full mask");
    send_exp(2'b00, 64'hDEAD_BEEF_0BAD_F00D, 64'h0, 64'h0, "R4 gather empty");
    send_exp(2'b01, 64'hDEAD_BEEF_0BAD_F00D, 64'h0, 64'h0, "R4 scatter empty");
    send_exp(2'b10, 64'hDEAD_BEEF_0BAD_F00D, 64'h0,
             64'hDEAD_BEEF_0BAD_F00D, "R4 split empty");
    send_exp(2'b11, 64'hCAFE_F00D_1234_5678, 64'hFFFF_0000_FFFF_0000,
             64'hCAFE_F00D_1234_5678, "R5 pass");
    send_exp(2'b00, 64'h5555_5555_5555_5555, 64'hFFFF_FFFF_FFFF_FFFF,
             64'h5555_5555_5555_5555, "R1 full mask");
    idle(3);

    // Back-to-back runs rotating opcodes, with gaps
    for (int blk = 0; blk < 40; blk++) begin
      for (int j = 0; j < 12; j++) begin
        s = {$urandom, $urandom};
        case ($urandom % 6)
          0:       m = '0;
          1:       m = '1;
          2:       m = 64'h1 << ($urandom % W);
          3:       m = {$urandom, $urandom} & {$urandom, $urandom};
          default: m = {$urandom, $urandom};
        endcase
        send(2'((blk + j) % 4), s, m);
      end
      idle(1 + blk % 3);
    end

    idle(3);
    check("R6 drained", W'(sbq.size()), '0);
    finish_run();
  end
endmodule